// File: doc/BRIEF.md
# Fully Associative Write-Back Byte Cache

This block is a small cache between a byte-wide requester and a backing memory that moves one 32-bit word per handshake. Addresses are 8 bits wide. The cache holds four 8-byte blocks, and any block may sit in any slot. There is no index field. On each request the block compares every valid slot's tag in parallel.

Writes stay in the cache and mark their slot dirty. A write miss first brings the whole block in and then merges the byte. When every slot is occupied, a miss replaces the least recently used slot. If that slot is dirty, its whole block is first streamed back to memory.

The requester issues one access at a time with a valid/ready handshake and gets exactly one response pulse. Each memory beat is a separate valid/ready handshake that carries a word-aligned byte address.

Top module: `assoc_wb_cache`

## Requirements
- R1: The request address splits into tag = addr[7:3] and byte offset = addr[2:0]. An access hits when a valid slot holds the same tag, and a read returns the byte at that offset within the block.
- R2: After reset every slot is invalid, so the first access to any block misses and fetches it. Directly after reset, req_ready is 1 and both resp_valid and mem_valid are 0.
- R3: req_ready is 1 only while the cache is idle. Each accepted request produces exactly one one-cycle resp_valid pulse. resp_hit is 1 when the tag matched at first lookup. A hit responds two clock edges after the accepting edge.
- R4: A write hit replaces only the addressed byte, marks the slot dirty, and causes no memory traffic.
- R5: A write miss fetches the block from memory, then merges the written byte; the bytes around it keep their memory values and no memory write occurs for the store itself.
- R6: While any slot is invalid, a miss fills an invalid slot and evicts nothing, so the first four distinct blocks all stay resident.
- R7: When all slots are valid, a miss replaces the least recently used block. Both a hit and a fill make their slot the most recently used.
- R8: A dirty victim is written back in full before the new block is fetched. The write-back is two beats, at addresses tag*8 and tag*8+4, lower word first. The fetch uses the same beat order.
- R9: Each memory beat holds mem_valid, mem_write, mem_addr and mem_wdata steady until mem_ready is seen. A word carries the byte at its lowest address in bits [7:0].
- R10: A block that was only read is clean, and evicting it issues no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester presents an access |
| req_ready | output | 1 | Cache can accept an access this cycle |
| req_write | input | 1 | 1 = store byte, 0 = load byte |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Byte to store |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Access hit at first lookup |
| resp_rdata | output | 8 | Loaded byte |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory completes the beat this cycle |
| mem_write | output | 1 | 1 = write-back beat, 0 = fetch beat |
| mem_addr | output | 8 | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Write-back word |
| mem_rdata | input | 32 | Fetched word, valid while mem_ready is high |

## Verification
The bench drives access sequences whose recency order it tracks by hand, so that each miss has a known victim. A design that picks the wrong slot makes a recently touched block miss, or leaves an evicted block hitting. The bench logs every memory beat. This catches a dirty bit that a read sets, which shows up as a write-back the bench does not expect, and a lost dirty bit, which shows up as a missing write-back or stale data after the block returns. It also catches a write-back that comes after the fetch or in the wrong beat order. A mode in which the memory withholds ready on alternate cycles checks that beats hold steady and that a stall never advances the beat counter.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
    // Controller phases: wait for a request, compare tags, stream a dirty
    // victim out, stream the missing block in.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_EVICT = 2'd2,
        ST_FETCH = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/fa_tag_match.sv
// Parallel tag compare across all slots.
module fa_tag_match #(
    parameter int NUM_SLOTS = 4,
    parameter int TAG_W     = 5,
    parameter int SLOT_W    = 2
) (
    input  logic [NUM_SLOTS-1:0]            slot_valid,
    input  logic [NUM_SLOTS-1:0][TAG_W-1:0] slot_tags,
    input  logic [TAG_W-1:0]                look_tag,
    output logic                            hit,
    output logic [SLOT_W-1:0]               hit_slot
);
    logic [NUM_SLOTS-1:0] match;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
            assign match[g] = slot_valid[g] && (slot_tags[g] == look_tag);
        end
    endgenerate

    always_comb begin
        hit_slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (match[i]) hit_slot = SLOT_W'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/fa_victim_sel.sv
// Lowest-numbered free slot wins; with none free, the recency tracker's pick.
module fa_victim_sel #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic [NUM_SLOTS-1:0] slot_valid,
    input  logic [SLOT_W-1:0]    lru_slot,
    output logic [SLOT_W-1:0]    victim,
    output logic                 victim_free
);
    always_comb begin
        victim      = lru_slot;
        victim_free = 1'b0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!slot_valid[i]) begin
                victim      = SLOT_W'(i);
                victim_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fa_recency.sv
// Full recency list: entry 0 is least recent, the last entry most recent.
module fa_recency #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch_en,
    input  logic [SLOT_W-1:0] touch_slot,
    output logic [SLOT_W-1:0] lru_slot
);
    logic [NUM_SLOTS-1:0][SLOT_W-1:0] order_d, order_q;
    logic [SLOT_W-1:0]                pos;

    always_comb begin
        pos = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (order_q[i] == touch_slot) pos = SLOT_W'(i);
        end
        order_d = order_q;
        if (touch_en) begin
            for (int i = 0; i < NUM_SLOTS - 1; i++) begin
                if (i >= int'(pos)) order_d[i] = order_q[i+1];
            end
            order_d[NUM_SLOTS-1] = touch_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) order_q[i] <= SLOT_W'(i);
        end else begin
            order_q <= order_d;
        end
    end

    assign lru_slot = order_q[0];
endmodule

// File: rtl/assoc_wb_cache.sv
module assoc_wb_cache
    import fa_cache_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int OFFSET_W  = 3,
    parameter int NUM_SLOTS = 4,
    parameter int WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [7:0]        resp_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int TAG_W       = ADDR_W - OFFSET_W;
    localparam int BLOCK_BYTES = 1 << OFFSET_W;
    localparam int BLOCK_W     = BLOCK_BYTES * 8;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int WOFF_W      = $clog2(WORD_BYTES);
    localparam int BEATS       = BLOCK_BYTES / WORD_BYTES;
    localparam int BEAT_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        ctl_state_e                          st;
        logic [SLOT_W-1:0]                   victim;
        logic [BEAT_W-1:0]                   beat;
        logic [TAG_W-1:0]                    tag;
        logic [OFFSET_W-1:0]                 off;
        logic                                wr;
        logic [7:0]                          wdata;
        logic                                missed;
        logic                                resp_valid;
        logic                                resp_hit;
        logic [7:0]                          rdata;
        logic [NUM_SLOTS-1:0]                valid;
        logic [NUM_SLOTS-1:0]                dirty;
        logic [NUM_SLOTS-1:0][TAG_W-1:0]     tags;
        logic [NUM_SLOTS-1:0][BLOCK_W-1:0]   data;
    } regs_t;

    regs_t r_d, r_q;

    logic              hit;
    logic [SLOT_W-1:0] hit_slot;
    logic [SLOT_W-1:0] lru_slot;
    logic [SLOT_W-1:0] pick;
    logic              pick_free;
    logic              touch_en;
    logic [SLOT_W-1:0] touch_slot;
    logic              last_beat;
    logic [OFFSET_W-1:0] beat_off;

    fa_tag_match #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_match (
        .slot_valid (r_q.valid),
        .slot_tags  (r_q.tags),
        .look_tag   (r_q.tag),
        .hit        (hit),
        .hit_slot   (hit_slot)
    );

    fa_recency #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_recency (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_slot (touch_slot),
        .lru_slot   (lru_slot)
    );

    fa_victim_sel #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_victim (
        .slot_valid  (r_q.valid),
        .lru_slot    (lru_slot),
        .victim      (pick),
        .victim_free (pick_free)
    );

    assign last_beat = (r_q.beat == BEAT_W'(BEATS - 1));
    assign beat_off  = OFFSET_W'(OFFSET_W'(r_q.beat) << WOFF_W);

    always_comb begin
        r_d            = r_q;
        r_d.resp_valid = 1'b0;
        touch_en       = 1'b0;
        touch_slot     = hit_slot;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.tag    = req_addr[ADDR_W-1:OFFSET_W];
                    r_d.off    = req_addr[OFFSET_W-1:0];
                    r_d.wr     = req_write;
                    r_d.wdata  = req_wdata;
                    r_d.missed = 1'b0;
                    r_d.st     = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (hit) begin
                    r_d.resp_valid = 1'b1;
                    r_d.resp_hit   = !r_q.missed;
                    r_d.rdata      = r_q.data[hit_slot][r_q.off*8 +: 8];
                    if (r_q.wr) begin
                        r_d.data[hit_slot][r_q.off*8 +: 8] = r_q.wdata;
                        r_d.dirty[hit_slot]                = 1'b1;
                    end
                    touch_en = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.missed = 1'b1;
                    r_d.victim = pick;
                    r_d.beat   = '0;
                    r_d.st     = (!pick_free && r_q.dirty[pick]) ? ST_EVICT : ST_FETCH;
                end
            end
            ST_EVICT: begin
                if (mem_ready) begin
                    if (last_beat) begin
                        r_d.beat                = '0;
                        r_d.valid[r_q.victim]   = 1'b0;
                        r_d.dirty[r_q.victim]   = 1'b0;
                        r_d.st                  = ST_FETCH;
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ready) begin
                    r_d.data[r_q.victim][r_q.beat*WORD_W +: WORD_W] = mem_rdata;
                    if (last_beat) begin
                        r_d.beat              = '0;
                        r_d.tags[r_q.victim]  = r_q.tag;
                        r_d.valid[r_q.victim] = 1'b1;
                        r_d.dirty[r_q.victim] = 1'b0;
                        touch_en              = 1'b1;
                        touch_slot            = r_q.victim;
                        r_d.st                = ST_LOOK;
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign resp_valid = r_q.resp_valid;
    assign resp_hit   = r_q.resp_hit;
    assign resp_rdata = r_q.rdata;
    assign mem_valid  = (r_q.st == ST_EVICT) || (r_q.st == ST_FETCH);
    assign mem_write  = (r_q.st == ST_EVICT);
    assign mem_addr   = (r_q.st == ST_EVICT) ? {r_q.tags[r_q.victim], beat_off}
                                             : {r_q.tag, beat_off};
    assign mem_wdata  = r_q.data[r_q.victim][r_q.beat*WORD_W +: WORD_W];
endmodule

// File: rtl/fa_cache_checker.sv
module fa_cache_checker #(
    parameter int ADDR_W   = 8,
    parameter int OFFSET_W = 3,
    parameter int WORD_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata
);
    assert_one_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_accept_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!resp_valid && !req_ready));

    assert_port_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && mem_valid));

    assert_beat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                       && (!mem_write || $stable(mem_wdata))));

    assert_wb_before_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write) |=> !(mem_valid && mem_write));

    assert_first_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> (mem_addr[OFFSET_W-1:0] == '0));
endmodule

bind assoc_wb_cache fa_cache_checker #(
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W),
    .WORD_W   (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/sim_assoc_wb_cache.sv
`timescale 1ns/1ps
module sim_assoc_wb_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        resp_valid;
    logic        resp_hit;
    logic [7:0]  resp_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic        mem_write;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    logic [7:0]  golden [256];
    logic [31:0] mem_words [64];
    logic [7:0]  log_addr [64];
    logic        log_wr [64];
    logic [31:0] log_data [64];
    int          log_n = 0;
    bit          stall_mode = 1'b0;
    bit          tog = 1'b0;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    assoc_wb_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem_words[mem_addr[7:2]];

    // Memory ready pattern, changed away from the active edge.
    initial forever begin
        @(negedge clk);
        if (stall_mode) begin
            tog       = ~tog;
            mem_ready = tog;
        end else begin
            mem_ready = 1'b1;
        end
    end

    // Beat logger and backing store update.
    initial forever begin
        @(posedge clk);
        if (rst_n && mem_valid && mem_ready) begin
            if (log_n < 64) begin
                log_addr[log_n] = mem_addr;
                log_wr[log_n]   = mem_write;
                log_data[log_n] = mem_write ? mem_wdata : mem_rdata;
            end
            log_n++;
            if (mem_write) mem_words[mem_addr[7:2]] = mem_wdata;
        end
    end

    function automatic logic [31:0] gword(input int a);
        return {golden[a+3], golden[a+2], golden[a+1], golden[a]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] wd,
                          output logic hit, output logic [7:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        hit = resp_hit;
        rd  = resp_rdata;
        if (wr) golden[a] = wd;
    endtask

    task automatic expect_read(input logic [7:0] a, input bit exp_hit, input string req);
        logic h; logic [7:0] d; int l;
        access(1'b0, a, 8'h00, h, d, l);
        check(h == exp_hit, req, "hit flag", int'(h), int'(exp_hit));
        check(d == golden[a], req, "read byte", int'(d), int'(golden[a]));
        if (exp_hit) check(l == 2, req, "hit latency", l, 2);
    endtask

    task automatic expect_beat(input int idx, input bit wr, input logic [7:0] a, input string req);
        check(log_wr[idx] == wr, req, "beat direction", int'(log_wr[idx]), int'(wr));
        check(log_addr[idx] == a, req, "beat address", int'(log_addr[idx]), int'(a));
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R2", "ready after reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R2", "resp after reset", int'(resp_valid), 0);
        check(mem_valid == 1'b0, "R2", "mem idle after reset", int'(mem_valid), 0);
    endtask

    task automatic t_cold_fill();
        int base = log_n;
        expect_read(8'h00, 1'b0, "R2");
        check(log_n - base == 2, "R1", "fetch beat count", log_n - base, 2);
        expect_beat(base, 1'b0, 8'h00, "R1");
        expect_beat(base + 1, 1'b0, 8'h04, "R1");
        expect_read(8'h05, 1'b1, "R1");
        base = log_n;
        expect_read(8'h08, 1'b0, "R6");
        expect_read(8'h10, 1'b0, "R6");
        expect_read(8'h18, 1'b0, "R6");
        check(log_n - base == 6, "R6", "fill beats only", log_n - base, 6);
        for (int i = base; i < log_n; i++) check(log_wr[i] == 1'b0, "R6", "no eviction", int'(log_wr[i]), 0);
        // order becomes B1,B2,B3,B0
        expect_read(8'h0F, 1'b1, "R6");
        expect_read(8'h17, 1'b1, "R6");
        expect_read(8'h1F, 1'b1, "R6");
        expect_read(8'h00, 1'b1, "R6");
    endtask

    task automatic t_lru();
        int base = log_n;
        expect_read(8'h20, 1'b0, "R7");          // evicts B1 (clean)
        check(log_n - base == 2, "R10", "clean victim beats", log_n - base, 2);
        expect_beat(base, 1'b0, 8'h20, "R10");
        expect_read(8'h09, 1'b0, "R7");          // B1 gone; evicts B2
        expect_read(8'h03, 1'b1, "R7");          // B0 survived
    endtask

    task automatic t_write_hit();
        logic h; logic [7:0] d; int l;
        int base = log_n;
        access(1'b1, 8'h1A, 8'h5C, h, d, l);
        check(h == 1'b1, "R4", "write hit flag", int'(h), 1);
        check(l == 2, "R4", "write hit latency", l, 2);
        check(log_n == base, "R4", "no memory traffic", log_n - base, 0);
        expect_read(8'h1A, 1'b1, "R4");
        expect_read(8'h1B, 1'b1, "R4");
    endtask

    task automatic t_dirty_evict();
        int base;
        expect_read(8'h21, 1'b1, "R7");
        expect_read(8'h0A, 1'b1, "R7");
        expect_read(8'h04, 1'b1, "R7");          // LRU now dirty B3
        base = log_n;
        expect_read(8'h28, 1'b0, "R8");
        check(log_n - base == 4, "R8", "evict plus fetch beats", log_n - base, 4);
        expect_beat(base, 1'b1, 8'h18, "R8");
        expect_beat(base + 1, 1'b1, 8'h1C, "R8");
        expect_beat(base + 2, 1'b0, 8'h28, "R8");
        expect_beat(base + 3, 1'b0, 8'h2C, "R8");
        check(log_data[base] == gword(8'h18), "R9", "write-back word lanes",
              int'(log_data[base]), int'(gword(8'h18)));
        base = log_n;
        expect_read(8'h1A, 1'b0, "R8");          // returns stored byte from memory
        check(log_n - base == 2, "R10", "clean victim no write", log_n - base, 2);
    endtask

    task automatic t_write_miss();
        logic h; logic [7:0] d; int l;
        int base = log_n;
        access(1'b1, 8'h33, 8'hE1, h, d, l);
        check(h == 1'b0, "R5", "write miss flag", int'(h), 0);
        check(log_n - base == 2, "R5", "allocate beats", log_n - base, 2);
        expect_beat(base, 1'b0, 8'h30, "R5");
        expect_beat(base + 1, 1'b0, 8'h34, "R5");
        expect_read(8'h33, 1'b1, "R5");
        expect_read(8'h32, 1'b1, "R5");
    endtask

    task automatic t_stall();
        int base;
        stall_mode = 1'b1;
        base = log_n;
        expect_read(8'h44, 1'b0, "R9");          // evicts clean B0
        check(log_n - base == 2, "R9", "stalled fetch beats", log_n - base, 2);
        expect_beat(base, 1'b0, 8'h40, "R9");
        expect_beat(base + 1, 1'b0, 8'h44, "R9");
        expect_read(8'h29, 1'b1, "R9");
        expect_read(8'h18, 1'b1, "R9");          // LRU now dirty B6
        base = log_n;
        expect_read(8'h50, 1'b0, "R8");
        check(log_n - base == 4, "R8", "stalled evict beats", log_n - base, 4);
        expect_beat(base, 1'b1, 8'h30, "R8");
        expect_beat(base + 1, 1'b1, 8'h34, "R8");
        expect_beat(base + 2, 1'b0, 8'h50, "R8");
        check(log_data[base] == gword(8'h30), "R9", "stalled write-back word",
              int'(log_data[base]), int'(gword(8'h30)));
        stall_mode = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) golden[i] = 8'(i * 29 + 17);
        for (int w = 0; w < 64; w++) mem_words[w] = gword(w * 4);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_fill();
        t_lru();
        t_write_hit();
        t_dirty_evict();
        t_write_miss();
        t_stall();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule